// File: doc/BRIEF.md
# Multi-FIFO Interprocessor Mailbox

This block lets several processors pass 32-bit words to each other through a set of small hardware queues placed on a simple memory-mapped register bus. A sender pushes a word into a queue by writing that queue's message register. A receiver takes out the oldest word by reading the same register. For every queue, two read-only registers report whether it is full and how many words it holds.

Each queue raises two events. The "message waiting" event is present while the queue holds at least one word. The "space free" event is present while the queue is not full. Every interrupt user keeps its own sticky copy of all events, with its own enable mask. Enables are set and cleared through two separate registers, and status bits are acknowledged by writing 1 to them. The block drives one interrupt line per user.

A two-state access machine serves the bus. In `ST_IDLE` a raised `req` is accepted, and the register action (push, pop, enable or acknowledge) takes effect at that clock edge. The transition `IDLE->DONE` follows. In `ST_DONE` the block raises `ack` for exactly one cycle and presents read data. The unconditional transition `DONE->IDLE` follows, and `req` is ignored while in `ST_DONE`.

Top module: `mbx_top`

## Requirements
- R1: A read at byte offset 0x000 returns the constant parameter `REV_ID` (default 0x0000_0301).
- R2: Writing the message register of queue m (offset 0x040 + 4*m) appends the word. Reading it returns the oldest word and removes it, so words come out in first-in-first-out order.
- R3: A write to a full queue is discarded and leaves its contents and count unchanged. A read of an empty queue returns zero and leaves the count at zero.
- R4: The full-flag register of queue m (offset 0x080 + 4*m) reads 1 in bit 0 when the queue holds DEPTH words, and reads 0 otherwise.
- R5: The count register of queue m (offset 0x0c0 + 4*m) returns the number of words held, from 0 to DEPTH.
- R6: In the status register of user u (offset 0x104 + 0x10*u), bit 2*m is set while queue m is non-empty and bit 2*m+1 is set while queue m is not full. A set bit stays set until it is acknowledged.
- R7: Writing 1s to a status register clears those bits, and 0 bits are untouched. A cleared bit whose event has gone stays clear. A cleared bit whose event is still present is set again one cycle later.
- R8: Writing 1s to the enable-set register of user u (offset 0x108 + 0x10*u) sets those enable bits. Writing 1s to the enable-clear register (offset 0x10c + 0x10*u) clears them. Both registers read back the current enable mask.
- R9: `irq[u]` is high exactly when some bit is set in both the status and the enable mask of user u. It follows an enable change right after the write edge, and a new event one cycle later.
- R10: An accepted request is answered by `ack` for exactly one cycle, in the cycle after acceptance, with read data valid alongside it.
- R11: Reset empties every queue and clears all enables and status. While reset is held, `ack` and every `irq` are low.
- R12: Reads of unmapped offsets (a queue index ≥ NFIFO, a user index ≥ NUSER, gaps) return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW (9) | Byte offset of the register |
| wdata | input | DW (32) | Write data |
| ack | output | 1 | One-cycle access completion |
| rdata | output | DW (32) | Read data, valid with `ack` |
| irq | output | NUSER (3) | One interrupt line per user |

## Verification
Every register action (push, pop, enable change, acknowledge) takes effect on the accepting edge. `ack` and read data follow one cycle later, so the bench samples them on the falling edge after acceptance. A queue event reaches a user's sticky status one cycle after the queue changes. A dependent interrupt line therefore rises one full cycle after the `ack` of the push, and the bench samples once at `ack` (still low) and once a cycle later (high). Because consecutive accesses are two cycles apart, every status read already reflects the previous access, including a re-set after an acknowledge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } mbx_state_e;

    // Address blocks of 64 bytes selected by addr[AW-1:6]
    localparam int BLK_MSG   = 1;
    localparam int BLK_FULL  = 2;
    localparam int BLK_COUNT = 3;

    // User register group base and slot codes within a group
    localparam int USR_BASE  = 'h100;
    localparam int SLOT_STAT = 1;
    localparam int SLOT_ESET = 2;
    localparam int SLOT_ECLR = 3;

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_drop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (count == $past(count)));
    assert_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (count == '0));

endmodule

// File: rtl/mbx_user.sv
module mbx_user #(
    parameter int NEV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] cond,
    input  logic           ack_wr,
    input  logic           set_wr,
    input  logic           clr_wr,
    input  logic [NEV-1:0] mask,
    output logic [NEV-1:0] status,
    output logic [NEV-1:0] enable,
    output logic           irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            if (ack_wr) status <= status & ~mask;
            else        status <= status | cond;
            if (set_wr)      enable <= enable | mask;
            else if (clr_wr) enable <= enable & ~mask;
        end
    end

    assign irq = |(status & enable);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((status & $past(mask)) == '0));
    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_wr |=> ((status & $past(cond)) == $past(cond)));
    assert_enable_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((enable & $past(mask)) == $past(mask)));
    assert_enable_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_wr) |=> ((enable & $past(mask)) == '0));

endmodule

// File: rtl/mbx_bus.sv
module mbx_bus
    import mbx_pkg::*;
#(
    parameter int          DW     = 32,
    parameter int          AW     = 9,
    parameter int          NFIFO  = 4,
    parameter int          NUSER  = 3,
    parameter int          NEV    = 8,
    parameter int          CW     = 3,
    parameter logic [31:0] REV_ID = 32'h0000_0301
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    input  logic [NFIFO-1:0][DW-1:0]    heads,
    input  logic [NFIFO-1:0][CW-1:0]    counts,
    input  logic [NFIFO-1:0]            fulls,
    input  logic [NUSER-1:0][NEV-1:0]   status,
    input  logic [NUSER-1:0][NEV-1:0]   enable,
    output logic [NFIFO-1:0]            push,
    output logic [NFIFO-1:0]            pop,
    output logic [NUSER-1:0]            ack_wr,
    output logic [NUSER-1:0]            set_wr,
    output logic [NUSER-1:0]            clr_wr,
    output logic [NEV-1:0]              mask,
    output logic                        ack,
    output logic [DW-1:0]               rdata
);
    localparam int RW = AW - 6;
    localparam int UW = AW - 4;

    mbx_state_e    state, nxt;
    logic          accept;
    logic [RW-1:0] region;
    logic [3:0]    fidx;
    logic [AW-1:0] uoff;
    logic [UW-1:0] uidx;
    logic [1:0]    uslot;
    logic          uhit;
    logic [DW-1:0] rd_val;
    logic          unused_bits;

    assign region      = addr[AW-1:6];
    assign fidx        = addr[5:2];
    assign uoff        = addr - AW'(USR_BASE);
    assign uidx        = uoff[AW-1:4];
    assign uslot       = uoff[3:2];
    assign uhit        = (addr >= AW'(USR_BASE)) && (uslot != 2'd0);
    assign mask        = wdata[NEV-1:0];
    assign unused_bits = ^{addr[1:0], uoff[1:0], wdata};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = req ? ST_DONE : ST_IDLE;
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // Outputs of the access machine
    always_comb begin
        ack    = (state == ST_DONE);
        accept = (state == ST_IDLE) && req;
    end

    // Register action strobes
    always_comb begin
        for (int f = 0; f < NFIFO; f++) begin
            push[f] = accept &&  we && (region == RW'(BLK_MSG)) && (fidx == 4'(f));
            pop[f]  = accept && !we && (region == RW'(BLK_MSG)) && (fidx == 4'(f));
        end
        for (int u = 0; u < NUSER; u++) begin
            ack_wr[u] = accept && we && uhit && (uidx == UW'(u)) && (uslot == 2'(SLOT_STAT));
            set_wr[u] = accept && we && uhit && (uidx == UW'(u)) && (uslot == 2'(SLOT_ESET));
            clr_wr[u] = accept && we && uhit && (uidx == UW'(u)) && (uslot == 2'(SLOT_ECLR));
        end
    end

    // Read selection
    always_comb begin
        rd_val = '0;
        if (addr[AW-1:2] == '0) rd_val = DW'(REV_ID);
        for (int f = 0; f < NFIFO; f++) begin
            if (fidx == 4'(f)) begin
                if (region == RW'(BLK_MSG))   rd_val = heads[f];
                if (region == RW'(BLK_FULL))  rd_val = DW'(fulls[f]);
                if (region == RW'(BLK_COUNT)) rd_val = DW'(counts[f]);
            end
        end
        for (int u = 0; u < NUSER; u++) begin
            if (uhit && (uidx == UW'(u))) begin
                if (uslot == 2'(SLOT_STAT)) rd_val = DW'(status[u]);
                else                        rd_val = DW'(enable[u]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)             rdata <= '0;
        else if (accept && !we) rdata <= rd_val;
    end

    assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_ack_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && req) |=> ack);
    assert_one_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, pop}));

endmodule

// File: rtl/mbx_top.sv
module mbx_top #(
    parameter int          DW     = 32,
    parameter int          AW     = 9,
    parameter int          NFIFO  = 4,
    parameter int          DEPTH  = 4,
    parameter int          NUSER  = 3,
    parameter logic [31:0] REV_ID = 32'h0000_0301
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic             ack,
    output logic [DW-1:0]    rdata,
    output logic [NUSER-1:0] irq
);
    localparam int NEV = 2 * NFIFO;
    localparam int CW  = $clog2(DEPTH + 1);

    logic [NFIFO-1:0][DW-1:0]  heads;
    logic [NFIFO-1:0][CW-1:0]  counts;
    logic [NFIFO-1:0]          full_v, empty_v, push_v, pop_v;
    logic [NEV-1:0]            cond, mask;
    logic [NUSER-1:0][NEV-1:0] status, enable;
    logic [NUSER-1:0]          ack_wr, set_wr, clr_wr;

    mbx_bus #(
        .DW(DW), .AW(AW), .NFIFO(NFIFO), .NUSER(NUSER),
        .NEV(NEV), .CW(CW), .REV_ID(REV_ID)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .heads(heads), .counts(counts), .fulls(full_v),
        .status(status), .enable(enable), .push(push_v), .pop(pop_v),
        .ack_wr(ack_wr), .set_wr(set_wr), .clr_wr(clr_wr), .mask(mask),
        .ack(ack), .rdata(rdata)
    );

    for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
        mbx_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(push_v[f]), .pop(pop_v[f]),
            .din(wdata), .head(heads[f]), .count(counts[f]),
            .full(full_v[f]), .empty(empty_v[f])
        );
        assign cond[2*f]   = ~empty_v[f];
        assign cond[2*f+1] = ~full_v[f];
    end

    for (genvar u = 0; u < NUSER; u++) begin : g_user
        mbx_user #(.NEV(NEV)) u_user (
            .clk(clk), .rst_n(rst_n), .cond(cond), .ack_wr(ack_wr[u]),
            .set_wr(set_wr[u]), .clr_wr(clr_wr[u]), .mask(mask),
            .status(status[u]), .enable(enable[u]), .irq(irq[u])
        );
    end

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> (irq == '0 && !ack));

endmodule

// File: tb/tb_mbx_top.sv
`timescale 1ns/1ps
module tb_mbx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbx_top dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .irq(irq)
    );

    // {req tag, write, offset, write data, expected read}
    localparam int NV = 27;
    localparam logic [77:0] VEC [NV] = '{
        {4'd1,  1'b0, 9'h000, 32'h0, 32'h0000_0301}, // R1
        {4'd5,  1'b0, 9'h0c0, 32'h0, 32'h0},          // R5
        {4'd2,  1'b1, 9'h040, 32'h1111_1111, 32'h0},
        {4'd2,  1'b1, 9'h040, 32'h2222_2222, 32'h0},
        {4'd5,  1'b0, 9'h0c0, 32'h0, 32'h2},          // R5
        {4'd4,  1'b0, 9'h080, 32'h0, 32'h0},          // R4
        {4'd6,  1'b0, 9'h104, 32'h0, 32'hAB},         // R6
        {4'd2,  1'b1, 9'h048, 32'h0000_000A, 32'h0},
        {4'd5,  1'b0, 9'h0c8, 32'h0, 32'h1},          // R5
        {4'd2,  1'b0, 9'h040, 32'h0, 32'h1111_1111},  // R2
        {4'd2,  1'b0, 9'h040, 32'h0, 32'h2222_2222},  // R2
        {4'd3,  1'b0, 9'h040, 32'h0, 32'h0},          // R3 empty read
        {4'd3,  1'b0, 9'h0c0, 32'h0, 32'h0},          // R3
        {4'd6,  1'b0, 9'h114, 32'h0, 32'hBB},         // R6 sticky
        {4'd7,  1'b1, 9'h114, 32'h01, 32'h0},
        {4'd7,  1'b0, 9'h114, 32'h0, 32'hBA},         // R7 stays clear
        {4'd7,  1'b1, 9'h114, 32'h10, 32'h0},
        {4'd7,  1'b0, 9'h114, 32'h0, 32'hBA},         // R7 re-set
        {4'd8,  1'b1, 9'h118, 32'h05, 32'h0},
        {4'd8,  1'b0, 9'h118, 32'h0, 32'h05},         // R8
        {4'd8,  1'b1, 9'h11c, 32'h04, 32'h0},
        {4'd8,  1'b0, 9'h118, 32'h0, 32'h01},         // R8
        {4'd8,  1'b0, 9'h11c, 32'h0, 32'h01},         // R8
        {4'd12, 1'b0, 9'h050, 32'h0, 32'h0},          // R12
        {4'd12, 1'b1, 9'h134, 32'hFF, 32'h0},
        {4'd12, 1'b0, 9'h134, 32'h0, 32'h0},          // R12
        {4'd12, 1'b0, 9'h0fc, 32'h0, 32'h0}           // R12
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [8:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        r = rdata;
        if (ack !== 1'b1) begin
            tests++; fails++;
            $display("FAIL R10: ack got %b expected 1 at %h", ack, a);
        end
        req = 1'b0; we = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        string tag;
        repeat (3) @(negedge clk);
        chk("R11 ack in reset", 32'(ack), 32'h0);
        chk("R11 irq in reset", 32'(irq), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            bus(VEC[i][73], VEC[i][72:64], VEC[i][63:32], r);
            if (!VEC[i][73]) begin
                tag = $sformatf("R%0d vec%0d", VEC[i][77:74], i);
                chk(tag, r, VEC[i][31:0]);
            end
        end

        // R10 handshake timing
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 9'h000;
        chk("R10 no ack idle", 32'(ack), 32'h0);
        @(negedge clk);
        chk("R10 ack", 32'(ack), 32'h1);
        chk("R10 data", rdata, 32'h0000_0301);
        req = 1'b0;
        @(negedge clk);
        chk("R10 ack one cycle", 32'(ack), 32'h0);

        // R3/R4 fill queue 1 and overflow
        for (int k = 1; k <= 4; k++) bus(1'b1, 9'h044, 32'hC0DE_0000 + 32'(k), r);
        bus(1'b1, 9'h044, 32'hDEAD_BEEF, r);
        bus(1'b0, 9'h084, 0, r); chk("R4 full flag", r, 32'h1);
        bus(1'b0, 9'h0c4, 0, r); chk("R3 count after drop", r, 32'h4);
        bus(1'b1, 9'h104, 32'h08, r);
        bus(1'b0, 9'h104, 0, r); chk("R7 not-full ack while full", r, 32'hB7);
        for (int k = 1; k <= 4; k++) begin
            bus(1'b0, 9'h044, 0, r);
            chk("R3 order kept after drop", r, 32'hC0DE_0000 + 32'(k));
            if (k == 1) begin
                bus(1'b0, 9'h104, 0, r); chk("R6 not-full re-raised", r, 32'hBF);
            end
        end
        bus(1'b0, 9'h084, 0, r); chk("R4 not full", r, 32'h0);

        // R9 interrupt lines
        @(negedge clk);
        chk("R9 irq idle", 32'(irq), 32'h0);
        bus(1'b1, 9'h128, 32'h02, r);
        chk("R9 irq2 on enable", 32'(irq[2]), 32'h1);
        bus(1'b1, 9'h12c, 32'h02, r);
        chk("R9 irq2 off", 32'(irq[2]), 32'h0);
        bus(1'b1, 9'h040, 32'h5555_0000, r);
        chk("R9 irq1 not yet", 32'(irq[1]), 32'h0);
        @(negedge clk);
        chk("R9 irq1 after event", 32'(irq[1]), 32'h1);
        chk("R9 irq0 masked", 32'(irq[0]), 32'h0);

        // R11 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 irq cleared", 32'(irq), 32'h0);
        rst_n = 1'b1;
        bus(1'b0, 9'h0c0, 0, r); chk("R11 queue empty", r, 32'h0);
        bus(1'b0, 9'h118, 0, r); chk("R11 enables clear", r, 32'h0);
        bus(1'b0, 9'h114, 0, r); chk("R11 status fresh", r, 32'hAA);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R10: watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule